// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers the four level-sensitive PCI interrupt pins (INTA through INTD, numbered 0 to 3) onto sixteen legacy ISA interrupt request lines that feed an 8259-style interrupt controller. Software chooses the destination of each pin by writing a 4-bit route code into one of three byte-wide configuration registers. The registers sit behind a small synchronous interface: writes commit on the rising clock edge, and reads return data combinationally from the address.

The route nibbles are not packed evenly. Pin 0 and pin 3 each use only the upper half of their byte. Pins 1 and 2 share the middle byte. A route code of 0, 2 or 15 leaves its pin unconnected. Several pins may select the same IRQ, and that IRQ is then the OR of their levels. The outputs are recomputed combinationally from the stored routes and the live pin levels, so a change of route moves an asserted interrupt in the cycle the write commits. Interrupts from internal functions are not routed separately. They are assumed to share a PCI pin.

Top module: `pirq_router`

## Requirements
- R1: After reset the bytes at offsets 0x55, 0x56 and 0x57 read 0x00 and every bit of `irq_out` is low, whatever the pin levels.
- R2: Pin 0 is routed by bits [7:4] of the byte at offset 0x55.
- R3: Pin 1 is routed by bits [3:0] of the byte at offset 0x56, and pin 2 is routed by bits [7:4] of that byte.
- R4: Pin 3 is routed by bits [7:4] of the byte at offset 0x57. Bits [3:0] of offsets 0x55 and 0x57 are stored and read back, but they route nothing.
- R5: A route code of 0, 2 or 15 disables its pin. A valid code n (1 or 3 to 14) drives `irq_out[n]`.
- R6: Each `irq_out[n]` is the OR of the levels of all enabled pins whose code is n. An IRQ shared by two pins stays high until both pins are low.
- R7: When a route byte is rewritten while a pin is high, the old IRQ falls and the new IRQ rises in the cycle after the write edge. This happens without any change on the pin.
- R8: A read at offset 0x55, 0x56 or 0x57 returns the whole stored byte on `cfg_rdata`. A read at any other offset returns 0x00.
- R9: A write to any offset other than 0x55 to 0x57 changes neither the stored bytes nor `irq_out`.
- R10: `irq_out` bits 0, 2 and 15 are always low.
- R11: A route byte changes only on a rising `clk` edge with `cfg_we` high. Presenting address and data with `cfg_we` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_addr | input | 8 | Configuration byte offset for reads and writes |
| cfg_we | input | 1 | Write enable, sampled on the rising clock edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| pin_lvl | input | 4 | Active-high levels of PCI interrupt pins 0 to 3 |
| irq_out | output | 16 | Active-high ISA interrupt request levels, index is the IRQ number |

## Verification
The bench goes after the uneven nibble packing. A design that used the low nibble of 0x55 or 0x57, or swapped the two halves of 0x56, would raise the wrong IRQ or raise one when none should rise. It drives codes 0, 2 and 15 with every pin high and expects silence, and it checks code 1 as the lowest valid code. A router that only decoded codes from 3 upward, or that treated 15 as valid, would be caught there. Two pins share one IRQ and are released one at a time. A design that let the last change win, instead of merging with OR, would drop the IRQ too early. A rewrite under an asserted pin, together with writes to neighbouring offsets and writes with the enable low, catches a stale route or a loose address decode.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Structural sizes of the router
  localparam int NUM_PINS  = 4;
  localparam int CODE_W    = 4;
  localparam int NUM_IRQ   = 16;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_BYTES = 3;

  // Route byte offsets; the nibble layout inside them is fixed behaviour
  localparam logic [ADDR_W-1:0] OFS_ROUTE_LO  = 8'h55;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_MID = 8'h56;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_HI  = 8'h57;

  // IRQ lines that can never be the target of a pin
  localparam logic [NUM_IRQ-1:0] FIXED_LOW_MASK = 16'h8005;

  // Route code check: 0, 2 and anything above 14 disconnect the pin
  function automatic logic code_enabled(input logic [CODE_W-1:0] code);
    return (code != 4'd0) && (code != 4'd2) && (code <= 4'd14);
  endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_PINS   = NUM_PINS,
  parameter int P_CODE_W = CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [P_ADDR_W-1:0]        cfg_addr,
  input  logic                       cfg_we,
  input  logic [P_DATA_W-1:0]        cfg_wdata,
  output logic [P_DATA_W-1:0]        cfg_rdata,
  output logic [P_PINS*P_CODE_W-1:0] route_codes
);

  localparam int BYTES_W = NUM_BYTES * P_DATA_W;

  logic [P_DATA_W-1:0] byte_q   [NUM_BYTES];
  logic [P_DATA_W-1:0] byte_nxt [NUM_BYTES];
  logic [NUM_BYTES-1:0] hit;
  logic [BYTES_W-1:0]   bytes_flat;

  // Per-byte address decode, next state and register
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    localparam logic [P_ADDR_W-1:0] OFS = OFS_ROUTE_LO + P_ADDR_W'(k);

    always_comb begin
      hit[k] = (cfg_addr == OFS);
    end

    always_comb begin
      byte_nxt[k] = byte_q[k];
      if (cfg_we && hit[k]) begin
        byte_nxt[k] = cfg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[k] <= '0;
      end else if (cfg_we && hit[k]) begin
        byte_q[k] <= byte_nxt[k];
      end
    end

    assign bytes_flat[k*P_DATA_W +: P_DATA_W] = byte_q[k];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == OFS) |=> (byte_q[k] == $past(cfg_wdata))); // R11
  end

  // Read mux: full byte at a route offset, zero elsewhere
  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (hit[k]) begin
        cfg_rdata = byte_q[k];
      end
    end
  end

  // Uneven nibble packing: pin0 hi(0x55), pin1 lo(0x56), pin2 hi(0x56), pin3 hi(0x57)
  always_comb begin
    route_codes = '0;
    route_codes[0*P_CODE_W +: P_CODE_W] = byte_q[0][P_DATA_W-1 -: P_CODE_W];
    route_codes[1*P_CODE_W +: P_CODE_W] = byte_q[1][P_CODE_W-1:0];
    route_codes[2*P_CODE_W +: P_CODE_W] = byte_q[1][P_DATA_W-1 -: P_CODE_W];
    route_codes[3*P_CODE_W +: P_CODE_W] = byte_q[2][P_DATA_W-1 -: P_CODE_W];
  end

  AST_FOREIGN_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && hit == '0) |=> $stable(bytes_flat)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we) |=> $stable(bytes_flat)); // R11

endmodule

// File: rtl/pirq_decode.sv
module pirq_decode
  import pirq_pkg::*;
#(
  parameter int P_CODE_W = CODE_W,
  parameter int P_IRQ    = NUM_IRQ
) (
  input  logic [P_CODE_W-1:0] code,
  output logic [P_IRQ-1:0]    sel
);

  logic valid;

  always_comb begin
    valid = code_enabled(code);
    sel   = '0;
    if (valid) begin
      sel[code] = 1'b1;
    end
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(sel)); // R5
  end

endmodule

// File: rtl/pirq_merge.sv
module pirq_merge
  import pirq_pkg::*;
#(
  parameter int               P_PINS = NUM_PINS,
  parameter int               P_IRQ  = NUM_IRQ,
  parameter logic [P_IRQ-1:0] P_MASK = FIXED_LOW_MASK
) (
  input  logic [P_PINS-1:0]       pin_lvl,
  input  logic [P_PINS*P_IRQ-1:0] sel_flat,
  output logic [P_IRQ-1:0]        irq
);

  logic [P_IRQ-1:0] gated [P_PINS];

  for (genvar p = 0; p < P_PINS; p++) begin : g_gate
    assign gated[p] = pin_lvl[p] ? sel_flat[p*P_IRQ +: P_IRQ] : '0;
  end

  // Wired-OR merge of all pins, fixed-low lines forced off
  always_comb begin
    irq = '0;
    for (int p = 0; p < P_PINS; p++) begin
      irq = irq | gated[p];
    end
    irq = irq & ~P_MASK;
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_PINS   = NUM_PINS,
  parameter int P_IRQ    = NUM_IRQ
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_ADDR_W-1:0] cfg_addr,
  input  logic                cfg_we,
  input  logic [P_DATA_W-1:0] cfg_wdata,
  output logic [P_DATA_W-1:0] cfg_rdata,
  input  logic [P_PINS-1:0]   pin_lvl,
  output logic [P_IRQ-1:0]    irq_out
);

  localparam int CW = CODE_W;

  logic [1:0]              rst_sync_q;
  logic [1:0]              rst_sync_nxt;
  logic                    rst_int_n;
  logic [P_PINS*CW-1:0]    route_codes;
  logic [P_PINS*P_IRQ-1:0] sel_flat;

  // Reset: asserts at once, leaves after two clock edges
  always_comb begin
    rst_sync_nxt = {rst_sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= rst_sync_nxt;
    end
  end

  assign rst_int_n = rst_sync_q[1];

  pirq_cfg_regs #(
    .P_ADDR_W (P_ADDR_W),
    .P_DATA_W (P_DATA_W),
    .P_PINS   (P_PINS),
    .P_CODE_W (CW)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_addr    (cfg_addr),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .route_codes (route_codes)
  );

  for (genvar p = 0; p < P_PINS; p++) begin : g_pin
    pirq_decode #(
      .P_CODE_W (CW),
      .P_IRQ    (P_IRQ)
    ) u_dec (
      .code (route_codes[p*CW +: CW]),
      .sel  (sel_flat[p*P_IRQ +: P_IRQ])
    );

    AST_PIN_REACHES_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
      (pin_lvl[p] && code_enabled(route_codes[p*CW +: CW]))
        |-> irq_out[route_codes[p*CW +: CW]]); // R6
  end

  pirq_merge #(
    .P_PINS (P_PINS),
    .P_IRQ  (P_IRQ),
    .P_MASK (FIXED_LOW_MASK)
  ) u_merge (
    .pin_lvl  (pin_lvl),
    .sel_flat (sel_flat),
    .irq      (irq_out)
  );

  AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_out & FIXED_LOW_MASK) == '0); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_out != '0) |-> (pin_lvl != '0)); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(irq_out) <= $countones(pin_lvl)); // R5

endmodule

// File: tb/pirq_router_bench.sv
`timescale 1ns/100ps
module pirq_router_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pin_lvl;
  logic [15:0] irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pirq_router u_pirq_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pin_lvl   (pin_lvl),
    .irq_out   (irq_out)
  );

  // {byte 0x55, byte 0x56, byte 0x57, pins, expected irq_out}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {8'h50, 8'h00, 8'h00, 4'h1, 16'h0020},  // R2 pin0 -> 5
    {8'h50, 8'h00, 8'h00, 4'hE, 16'h0000},  // R2 pin0 low
    {8'h00, 8'h07, 8'h00, 4'h2, 16'h0080},  // R3 pin1 -> 7
    {8'h00, 8'h90, 8'h00, 4'h4, 16'h0200},  // R3 pin2 -> 9
    {8'h00, 8'h00, 8'hE0, 4'h8, 16'h4000},  // R4 pin3 -> 14
    {8'h3F, 8'hBA, 8'hC4, 4'hF, 16'h1C08},  // R4 low nibbles ignored
    {8'h00, 8'h2F, 8'hF0, 4'hF, 16'h0000},  // R5 codes 0,15,2,15
    {8'h0B, 8'h00, 8'h0B, 4'hF, 16'h0000},  // R4 low nibble only
    {8'h10, 8'h00, 8'h00, 4'h1, 16'h0002},  // R5 code 1 valid
    {8'h40, 8'h44, 8'h60, 4'h7, 16'h0010}   // R6 three pins share 4
  };

  task automatic check16(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    #0.5;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a,
                          input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #0.5;
    check16(req, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pin_lvl = v;
    #0.5;
  endtask

  initial begin
    #50000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cfg_addr  = 8'h00;
    cfg_we    = 1'b0;
    cfg_wdata = 8'h00;
    pin_lvl   = 4'hF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #0.5;
    check16("R1 irq after reset", irq_out, 16'h0000);
    rd_check("R1 0x55 reset", 8'h55, 8'h00);
    rd_check("R1 0x56 reset", 8'h56, 8'h00);
    rd_check("R1 0x57 reset", 8'h57, 8'h00);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      wr(8'h55, VEC[i][43:36]);
      wr(8'h56, VEC[i][35:28]);
      wr(8'h57, VEC[i][27:20]);
      set_pins(VEC[i][19:16]);
      check16($sformatf("R6 vector %0d", i), irq_out, VEC[i][15:0]);
      check16("R10 fixed low", irq_out & 16'h8005, 16'h0000);
    end

    // R8 readback of full bytes
    wr(8'h55, 8'hA7);
    wr(8'h56, 8'h3C);
    wr(8'h57, 8'h5E);
    rd_check("R8 read 0x55", 8'h55, 8'hA7);
    rd_check("R8 read 0x56", 8'h56, 8'h3C);
    rd_check("R8 read 0x57", 8'h57, 8'h5E);
    rd_check("R8 read 0x54", 8'h54, 8'h00);

    // R6 shared IRQ released one pin at a time
    wr(8'h55, 8'h90);
    wr(8'h56, 8'h09);
    wr(8'h57, 8'h00);
    set_pins(4'h3);
    check16("R6 both high", irq_out, 16'h0200);
    set_pins(4'h2);
    check16("R6 one released", irq_out, 16'h0200);
    set_pins(4'h0);
    check16("R6 both released", irq_out, 16'h0000);

    // R7 reroute under an asserted pin
    wr(8'h56, 8'h00);
    wr(8'h55, 8'h50);
    set_pins(4'h1);
    check16("R7 before reroute", irq_out, 16'h0020);
    wr(8'h55, 8'h60);
    check16("R7 after reroute", irq_out, 16'h0040);

    // R9 foreign offsets
    wr(8'h54, 8'hFF);
    wr(8'h58, 8'hFF);
    check16("R9 irq unchanged", irq_out, 16'h0040);
    rd_check("R9 0x55 unchanged", 8'h55, 8'h60);
    rd_check("R9 0x54 still zero", 8'h54, 8'h00);
    rd_check("R9 0x58 still zero", 8'h58, 8'h00);

    // R11 data presented with write enable low
    @(negedge clk);
    cfg_addr  = 8'h55;
    cfg_wdata = 8'h30;
    cfg_we    = 1'b0;
    repeat (2) @(negedge clk);
    #0.5;
    check16("R11 no write without enable", irq_out, 16'h0040);
    rd_check("R11 byte held", 8'h55, 8'h60);

    // R1 reset clears routes again
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check16("R1 irq in reset", irq_out, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_check("R1 0x55 after second reset", 8'h55, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule